// File: doc/BRIEF.md
# Configurable Interrupt Line Conditioner

This block sits between a set of raw device interrupt lines and a downstream interrupt controller. Every line is first brought into the local clock domain through a two-stage synchroniser. It is then conditioned according to its own configuration, so that the controller sees one clean request bit per line.

Each line is configured independently. It can be edge or level sensitive, and active high or active low, which gives all four combinations. It also has a mask bit, and masking is applied as the last step before the request leaves the block.

- **Edge lines.** A qualifying transition is captured in a sticky bit. The bit stays set until the downstream controller pulses that line's clear strobe.
- **Level lines.** The request follows the input while the input is at its active level. A level line also reports a pending indication, whatever its mask, until the device releases the line.

Configuration is written one line at a time through a narrow write port that carries an index and a three-bit word.

Top module: `irq_line_conditioner`

## Requirements
- R1: After reset every line is edge sensitive, active high and masked, and `req_o` and `lvl_pend_o` are all zero.
- R2: A configuration write loads `cfg_wdata_i` into line `cfg_idx_i` when `cfg_we_i` is high. The word is decoded as follows:
  - bit 0 is the mode: 1 means level, 0 means edge.
  - bit 1 is the polarity: 1 means active low.
  - bit 2 is the mask: 1 means masked.

  A write whose index is not below N_LINES changes no line.
- R3: On an edge, active-high line, a low-to-high transition of `irq_raw_i` sets that line's request. The request is visible after the third rising clock edge that follows the input change. A high-to-low transition sets nothing.
- R4: On an edge, active-low line, a high-to-low transition sets the request with the same latency as R3. A low-to-high transition sets nothing.
- R5: An edge request stays set until `req_clr_i` for that line is pulsed. One transition gives exactly one request, so the request does not return while the input merely stays active. A new transition detected in the same cycle as the clear leaves the request set.
- R6: On a level line, `req_o` and `lvl_pend_o` follow the active level of the input two clock edges after the input changes. On an active-low line the active level is low. Both signals reassert for as long as the line remains active, and `req_clr_i` has no effect on a level line.
- R7: A masked line never drives `req_o` high. An edge captured while the line is masked appears on `req_o` once the line is unmasked. On a level line, `lvl_pend_o` still reports the active level while the line is masked.
- R8: A configuration write never creates an edge request by itself. A write that changes a line's mode or polarity discards that line's captured edge. A write that changes only the mask keeps it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_raw_i | input | N_LINES | Raw, asynchronous device interrupt lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Index of the line being configured |
| cfg_wdata_i | input | 3 | Configuration word: {mask, active_low, level} |
| req_clr_i | input | N_LINES | Per-line clear strobe for captured edge requests |
| req_o | output | N_LINES | Conditioned, masked request per line |
| lvl_pend_o | output | N_LINES | Level line held at its active level, independent of mask |

## Verification
The bench targets the following corner cases. For each, a design that got it wrong would show the symptom named after the dash.
- **Edge captured while masked, then a mask-only write.** A design that clears the sticky bit on every write would lose this interrupt.
- **Polarity flip on an idle line.** A design that keeps the old edge history would raise a phantom request from the write.
- **Clear strobe in the same cycle as a new edge.** A clear-wins design would drop a real event.
- **Mode round trip from edge to level and back.** A stale sticky bit would reappear as a request.

The bench also checks these behaviours:
- the exact synchroniser latency;
- that a falling edge is ignored on an active-high line and a rising edge on an active-low line;
- that clear strobes do not affect level lines;
- that an out-of-range index write leaves a neighbouring line untouched, which catches a truncated index decode.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

  localparam int CFG_W = 3;

  typedef struct packed {
    logic mask;
    logic low;
    logic level;
  } line_cfg_t;

  localparam line_cfg_t CFG_RST = '{mask: 1'b1, low: 1'b0, level: 1'b0};

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_cond_pkg::*;
#(
  parameter int N_LINES = 5,
  parameter int IDX_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [CFG_W-1:0]   wdata_i,
  output line_cfg_t          cfg_o [N_LINES],
  output logic [N_LINES-1:0] hit_o,
  output logic [N_LINES-1:0] chg_o
);

  line_cfg_t wcfg;
  assign wcfg = line_cfg_t'(wdata_i);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    line_cfg_t cfg_q;

    assign hit_o[i] = we_i && (idx_i == IDX_W'(i));
    // mode or polarity change invalidates captured edges
    assign chg_o[i] = hit_o[i] && ((wcfg.level != cfg_q.level) || (wcfg.low != cfg_q.low));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cfg_q <= CFG_RST;
      else if (hit_o[i]) cfg_q <= wcfg;
    end

    assign cfg_o[i] = cfg_q;
  end

endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond
  import irq_cond_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sync_i,
  input  line_cfg_t cfg_i,
  input  logic      wr_hit_i,
  input  logic      mode_chg_i,
  input  logic      new_low_i,
  input  logic      clr_i,
  output logic      req_o,
  output logic      pend_o
);

  logic act, hist_q, sticky_q, rise;

  assign act = sync_i ^ cfg_i.low;

  // history reloaded with the new polarity on any write to this line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hist_q <= 1'b0;
    else if (wr_hit_i) hist_q <= sync_i ^ new_low_i;
    else               hist_q <= act;
  end

  assign rise = act && !hist_q && !wr_hit_i && !cfg_i.level;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= 1'b0;
    else         sticky_q <= rise || (sticky_q && !clr_i && !mode_chg_i);
  end

  assign pend_o = cfg_i.level && act;
  assign req_o  = !cfg_i.mask && (cfg_i.level ? act : sticky_q);

  AST_EDGE_NEEDS_EDGE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sticky_q) |-> $past(!cfg_i.level)); // R3

  AST_CLR_DROPS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && $stable(sync_i)) |=> !sticky_q); // R5

  AST_LEVEL_NO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.level |-> !sticky_q); // R6

  AST_WRITE_NO_FALSE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_hit_i) |-> !$rose(sticky_q)); // R8

endmodule

// File: rtl/irq_line_conditioner.sv
module irq_line_conditioner
  import irq_cond_pkg::*;
#(
  parameter int N_LINES = 5,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_raw_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic [N_LINES-1:0] req_clr_i,
  output logic [N_LINES-1:0] req_o,
  output logic [N_LINES-1:0] lvl_pend_o
);

  logic [N_LINES-1:0] sync;
  logic [N_LINES-1:0] hit, chg;
  line_cfg_t          cfg [N_LINES];
  line_cfg_t          wcfg;

  assign wcfg = line_cfg_t'(cfg_wdata_i);

  irq_sync #(.W(N_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_raw_i),
    .q_o    (sync)
  );

  irq_cfg_regs #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .hit_o   (hit),
    .chg_o   (chg)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_cond
    irq_line_cond u_line (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_i     (sync[i]),
      .cfg_i      (cfg[i]),
      .wr_hit_i   (hit[i]),
      .mode_chg_i (chg[i]),
      .new_low_i  (wcfg.low),
      .clr_i      (req_clr_i[i]),
      .req_o      (req_o[i]),
      .pend_o     (lvl_pend_o[i])
    );

    AST_MASK_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_idx_i == IDX_W'(i) && wcfg.mask) |=> !req_o[i]); // R7
  end

endmodule

// File: tb/tb_irq_line_conditioner.sv
module tb_irq_line_conditioner;

  localparam int N     = 5;
  localparam int IDX_W = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   raw = '0;
  logic           we = 1'b0;
  logic [IDX_W-1:0] idx = '0;
  logic [2:0]     wdata = '0;
  logic [N-1:0]   clr = '0;
  logic [N-1:0]   req, pend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    line;
    bit    req;
    bit    pend;
    string tag;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  irq_line_conditioner #(.N_LINES(N)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_raw_i   (raw),
    .cfg_we_i    (we),
    .cfg_idx_i   (idx),
    .cfg_wdata_i (wdata),
    .req_clr_i   (clr),
    .req_o       (req),
    .lvl_pend_o  (pend)
  );

  task automatic expect_line(input int line, input bit r, input bit p, input string tag);
    exp_t e;
    e.line = line; e.req = r; e.pend = p; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(input int i, input bit lvl, input bit low, input bit msk);
    @(negedge clk);
    we = 1'b1; idx = IDX_W'(i); wdata = {msk, low, lvl};
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_clr(input int i);
    clr[i] = 1'b1;
    @(negedge clk);
    clr[i] = 1'b0;
  endtask

  // monitor: compare queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (e.line < 0) begin
          if (req !== '0 || pend !== '0) begin
            errors++;
            $display("FAIL %s: req=%b pend=%b expected req=0 pend=0", e.tag, req, pend);
          end
        end else if (req[e.line] !== e.req || pend[e.line] !== e.pend) begin
          errors++;
          $display("FAIL %s: line %0d req=%b pend=%b expected req=%b pend=%b",
                   e.tag, e.line, req[e.line], pend[e.line], e.req, e.pend);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_line(-1, 0, 0, "R1 reset outputs");

    // line 0: edge captured while masked at reset
    raw[0] = 1'b1; tick(4);
    expect_line(0, 0, 0, "R1 masked after reset");
    wcfg(0, 0, 0, 0);
    expect_line(0, 1, 0, "R7 R8 captured edge kept by mask-only write");
    pulse_clr(0);
    expect_line(0, 0, 0, "R5 clear");
    tick(3);
    expect_line(0, 0, 0, "R5 no repeat while line stays high");

    raw[0] = 1'b0; tick(4);
    expect_line(0, 0, 0, "R3 falling edge ignored");
    raw[0] = 1'b1; tick(2);
    expect_line(0, 0, 0, "R3 latency not yet");
    tick(1);
    expect_line(0, 1, 0, "R3 rising edge request");
    pulse_clr(0);
    expect_line(0, 0, 0, "R5 clear after rise");

    // line 1: edge, active low
    wcfg(1, 0, 1, 0);
    tick(4);
    expect_line(1, 0, 0, "R8 polarity write no false edge");
    raw[1] = 1'b1; tick(4);
    expect_line(1, 0, 0, "R4 rising ignored on active low");
    raw[1] = 1'b0; tick(2);
    expect_line(1, 0, 0, "R4 latency not yet");
    tick(1);
    expect_line(1, 1, 0, "R4 falling edge request");
    raw[1] = 1'b1; tick(4);
    expect_line(1, 1, 0, "R5 sticky holds");
    raw[1] = 1'b0; tick(2);
    pulse_clr(1);
    expect_line(1, 1, 0, "R5 new edge wins over clear");
    pulse_clr(1);
    expect_line(1, 0, 0, "R5 cleared");

    // line 2: level, active high
    wcfg(2, 1, 0, 0);
    expect_line(2, 0, 0, "R6 idle level line");
    raw[2] = 1'b1; tick(1);
    expect_line(2, 0, 0, "R6 two-flop latency");
    tick(1);
    expect_line(2, 1, 1, "R6 level high request");
    pulse_clr(2);
    expect_line(2, 1, 1, "R6 clear no effect on level");
    tick(3);
    expect_line(2, 1, 1, "R6 level persists");
    wcfg(2, 1, 0, 1);
    expect_line(2, 0, 1, "R7 masked level keeps pend");
    wcfg(2, 1, 0, 0);
    expect_line(2, 1, 1, "R6 reasserts when still active");
    raw[2] = 1'b0; tick(1);
    expect_line(2, 1, 1, "R6 release latency");
    tick(1);
    expect_line(2, 0, 0, "R6 released");

    // line 3: level, active low
    wcfg(3, 1, 1, 1);
    expect_line(3, 0, 1, "R7 masked active-low level");
    wcfg(3, 1, 1, 0);
    expect_line(3, 1, 1, "R6 active low request");
    raw[3] = 1'b1; tick(2);
    expect_line(3, 0, 0, "R6 active low released");
    raw[3] = 1'b0; tick(2);
    expect_line(3, 1, 1, "R6 active low again");

    // out-of-range index
    wcfg(7, 0, 0, 1);
    expect_line(3, 1, 1, "R2 out-of-range write leaves line 3");
    raw[4] = 1'b1; tick(4);
    expect_line(4, 0, 0, "R2 line 4 still masked");

    // mode round trip discards captured edge
    raw[0] = 1'b0; tick(4);
    raw[0] = 1'b1; tick(3);
    expect_line(0, 1, 0, "R3 edge before mode change");
    wcfg(0, 1, 0, 0);
    expect_line(0, 1, 1, "R6 switched to level");
    wcfg(0, 0, 0, 0);
    expect_line(0, 0, 0, "R8 mode change discards edge");

    tick(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule